// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block walks a chain of 16-byte transfer descriptors held in memory, beginning at a pointer supplied by the command sequencer. It fetches each descriptor with four 32-bit reads and decodes it. It then presents a single burst request (buffer address, byte count, direction, transfer mode) to a data mover and holds that request until the mover reports completion or a bus error.

After a completed entry that is not the final one, the walker follows that entry's next pointer and repeats. When the entry flagged as final completes, the walker returns a one-cycle done pulse. A malformed descriptor ends the walk with a sticky sequence-fault flag. A bus error from the mover ends it with a sticky host-bus error flag. Both flags clear when the next walk is started.

Top module: `prdw_walker`

## Requirements
- R1: After reset, busy, burst request, memory read request, done and both error flags are all low.
- R2: For each accepted descriptor, the burst carries the buffer address from word 0 and a byte count equal to the word-1 unit count times 8. Direction is 1 when bit 5 of the flags byte is set. The mode is bits 3:0 of the mode byte. Address, count, direction and mode stay stable while the request is held.
- R3: A descriptor at pointer P is read as four 32-bit words at P, P+4, P+8 and P+12, with one read outstanding at a time. Word 2 carries the flags byte in bits 7:0 and the mode byte in bits 15:8.
- R4: After a non-final entry completes, the next descriptor is fetched from that entry's next pointer (word 3). An entry with flags bit 7 set is final, and its next pointer is never fetched.
- R5: The cycle after the mover reports completion of the final entry, done is high for exactly one cycle and busy is low.
- R6: A descriptor whose unit count is zero issues no burst; the walk stops with the sequence-fault flag set.
- R7: A non-final descriptor whose next pointer has any of bits 2:0 set issues no burst; the walk stops with the sequence-fault flag set. An unaligned next pointer on a final entry is ignored.
- R8: A bus error from the mover stops the walk on the next cycle with the host-bus error flag set and no done pulse. When error and completion arrive in the same cycle, the error wins.
- R9: A start pulse while busy is ignored. A start while idle clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_ptr | input | AW | Byte address of the first descriptor |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data word |
| xfer_req | output | 1 | Burst request, held until done or error |
| xfer_addr | output | AW | Burst buffer address |
| xfer_bytes | output | 32+LEN_SHIFT | Burst byte count |
| xfer_dir | output | 1 | 1 = host to device |
| xfer_mode | output | MODE_W | Transfer mode for the burst |
| xfer_done | input | 1 | Mover reports burst completed |
| xfer_err | input | 1 | Mover reports bus error |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the final entry |
| err_seq | output | 1 | Sticky malformed-descriptor flag |
| err_bus | output | 1 | Sticky host-bus error flag |

## Verification
Burst completion and a bus error can arrive in the same cycle. On the final entry this decides whether done or the host-bus flag results. The bench provokes the collision by having its mover model raise both inputs together on a chosen final entry. The run is judged correct when done stays silent, the host-bus flag rises, and the walker is idle on the next cycle. Random chains also place single errors on earlier entries, and these are judged by counting the bursts issued before the stop.

// File: rtl/prdw_pkg.sv
package prdw_pkg;
   localparam int DESC_WORDS = 4;
   localparam int WI_BUF     = 0;
   localparam int WI_LEN     = 1;
   localparam int WI_CTL     = 2;
   localparam int WI_NEXT    = 3;
   localparam int FB_LAST    = 7;
   localparam int FB_DIR     = 5;
   localparam int MODE_LSB   = 8;

   typedef enum logic [1:0] {
      W_IDLE  = 2'd0,
      W_FETCH = 2'd1,
      W_XFER  = 2'd2
   } walk_st_t;
endpackage

// File: rtl/prdw_fetch.sv
module prdw_fetch #(
   parameter int AW = 32,
   parameter int NW = prdw_pkg::DESC_WORDS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [AW-1:0]        base,
   output logic                 rd_req,
   output logic [AW-1:0]        rd_addr,
   input  logic                 rd_valid,
   input  logic [31:0]          rd_data,
   output logic [NW-1:0][31:0]  words,
   output logic                 desc_valid
);
   localparam int IW = (NW > 1) ? $clog2(NW) : 1;

   logic          active, waiting, dv_q;
   logic [IW-1:0] idx;
   logic [AW-1:0] base_q;

   assign rd_req     = active && !waiting;
   assign rd_addr    = base_q + AW'({idx, 2'b00});
   assign desc_valid = dv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         waiting <= 1'b0;
         idx     <= '0;
         base_q  <= '0;
         dv_q    <= 1'b0;
      end else begin
         dv_q <= 1'b0;
         if (go) begin
            active  <= 1'b1;
            waiting <= 1'b0;
            idx     <= '0;
            base_q  <= base;
         end else if (rd_req) begin
            waiting <= 1'b1;
         end else if (waiting && rd_valid) begin
            waiting <= 1'b0;
            if (idx == IW'(NW-1)) begin
               active <= 1'b0;
               dv_q   <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= '0;
         else if (waiting && rd_valid && idx == IW'(g))
            words[g] <= rd_data;
      end
   end

   // R3: a single read in flight
   a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
endmodule

// File: rtl/prdw_check.sv
module prdw_check #(
   parameter int AW         = 32,
   parameter int MODE_W     = 4,
   parameter int ALIGN_LOG2 = 3,
   parameter int LEN_SHIFT  = 3,
   localparam int BYTES_W   = 32 + LEN_SHIFT
) (
   input  logic [prdw_pkg::DESC_WORDS-1:0][31:0] words,
   output logic [AW-1:0]      buf_addr,
   output logic [BYTES_W-1:0] bytes,
   output logic               dir,
   output logic [MODE_W-1:0]  mode,
   output logic               last,
   output logic [AW-1:0]      next_ptr,
   output logic               seq_fault
);
   import prdw_pkg::*;

   logic [31:0] units;
   logic        len_zero, misaligned;
   logic        unused_bits;

   assign units       = words[WI_LEN];
   assign buf_addr    = words[WI_BUF][AW-1:0];
   assign bytes       = {units, {LEN_SHIFT{1'b0}}};
   assign dir         = words[WI_CTL][FB_DIR];
   assign last        = words[WI_CTL][FB_LAST];
   assign mode        = words[WI_CTL][MODE_LSB +: MODE_W];
   assign next_ptr    = words[WI_NEXT][AW-1:0];
   assign len_zero    = (units == 32'd0);
   assign misaligned  = |next_ptr[ALIGN_LOG2-1:0];
   assign seq_fault   = len_zero || (!last && misaligned);
   assign unused_bits = ^words;
endmodule

// File: rtl/prdw_walker.sv
module prdw_walker #(
   parameter int AW         = 32,
   parameter int MODE_W     = 4,
   parameter int ALIGN_LOG2 = 3,
   parameter int LEN_SHIFT  = 3,
   parameter bit ERR_WINS   = 1'b1,
   localparam int BYTES_W   = 32 + LEN_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [AW-1:0]      start_ptr,
   output logic               mem_rd_req,
   output logic [AW-1:0]      mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [31:0]        mem_rd_data,
   output logic               xfer_req,
   output logic [AW-1:0]      xfer_addr,
   output logic [BYTES_W-1:0] xfer_bytes,
   output logic               xfer_dir,
   output logic [MODE_W-1:0]  xfer_mode,
   input  logic               xfer_done,
   input  logic               xfer_err,
   output logic               busy,
   output logic               done,
   output logic               err_seq,
   output logic               err_bus
);
   import prdw_pkg::*;

   if (AW < 5 || AW > 32) begin : g_bad_aw
      $fatal(1, "prdw_walker: AW must be 5..32");
   end
   if (MODE_W < 1 || MODE_W > 8) begin : g_bad_mode
      $fatal(1, "prdw_walker: MODE_W must be 1..8");
   end
   if (ALIGN_LOG2 < 1 || ALIGN_LOG2 > 4) begin : g_bad_align
      $fatal(1, "prdw_walker: ALIGN_LOG2 must be 1..4");
   end

   walk_st_t st;
   logic [DESC_WORDS-1:0][31:0] words;
   logic          desc_valid, go, last, seq_fault, ok_hit, err_hit;
   logic [AW-1:0] next_ptr, go_ptr;

   if (ERR_WINS) begin : g_err_first
      assign err_hit = xfer_err;
      assign ok_hit  = xfer_done && !xfer_err;
   end else begin : g_done_first
      assign ok_hit  = xfer_done;
      assign err_hit = xfer_err && !xfer_done;
   end

   assign xfer_req = (st == W_XFER);
   assign busy     = (st != W_IDLE);
   assign go       = (st == W_IDLE && start) || (xfer_req && ok_hit && !last);
   assign go_ptr   = (st == W_IDLE) ? start_ptr : next_ptr;

   prdw_fetch #(.AW(AW), .NW(DESC_WORDS)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(go), .base(go_ptr),
      .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
      .rd_valid(mem_rd_valid), .rd_data(mem_rd_data),
      .words(words), .desc_valid(desc_valid)
   );

   prdw_check #(.AW(AW), .MODE_W(MODE_W), .ALIGN_LOG2(ALIGN_LOG2),
                .LEN_SHIFT(LEN_SHIFT)) u_check (
      .words(words), .buf_addr(xfer_addr), .bytes(xfer_bytes),
      .dir(xfer_dir), .mode(xfer_mode), .last(last),
      .next_ptr(next_ptr), .seq_fault(seq_fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= W_IDLE;
         done    <= 1'b0;
         err_seq <= 1'b0;
         err_bus <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            W_IDLE: if (start) begin
               st      <= W_FETCH;
               err_seq <= 1'b0;
               err_bus <= 1'b0;
            end
            W_FETCH: if (desc_valid) begin
               if (seq_fault) begin
                  err_seq <= 1'b1;
                  st      <= W_IDLE;
               end else begin
                  st <= W_XFER;
               end
            end
            W_XFER: if (err_hit) begin
               err_bus <= 1'b1;
               st      <= W_IDLE;
            end else if (ok_hit) begin
               if (last) begin
                  done <= 1'b1;
                  st   <= W_IDLE;
               end else begin
                  st <= W_FETCH;
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   // R2: burst fields held while waiting on the mover
   a_r2_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_done && !xfer_err |=>
         xfer_req && $stable(xfer_addr) && $stable(xfer_bytes)
         && $stable(xfer_dir) && $stable(xfer_mode));
   // R2: no burst of zero bytes
   a_r2_nonzero_burst: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> xfer_bytes != '0);
   // R3: descriptor reads never overlap a burst
   a_r3_no_read_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !xfer_req);
   // R5: done is a single-cycle pulse and leaves the walker idle
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy ##1 !done);
   // R6, R7: a sequence fault never coexists with a burst
   a_r6_fault_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
      err_seq |-> !xfer_req);
   // R8: an error from the mover stops the walk with no done
   a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && xfer_err && (ERR_WINS || !xfer_done) |=>
         !busy && err_bus && !done);
endmodule

// File: tb/prdw_walker_bench.sv
module prdw_walker_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] start_ptr_i = '0;
   logic        mem_rd_req, mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_addr, mem_rd_data = '0;
   logic        xfer_req, xfer_dir, xfer_done = 1'b0, xfer_err = 1'b0;
   logic [31:0] xfer_addr;
   logic [34:0] xfer_bytes;
   logic [3:0]  xfer_mode;
   logic        busy, done, err_seq, err_bus;

   prdw_walker u_prdw_walker (
      .clk(clk), .rst_n(rst_n), .start(start_i), .start_ptr(start_ptr_i),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
      .xfer_dir(xfer_dir), .xfer_mode(xfer_mode),
      .xfer_done(xfer_done), .xfer_err(xfer_err),
      .busy(busy), .done(done), .err_seq(err_seq), .err_bus(err_bus)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int vectors = 0, miscompares = 0, cyc = 0;
   bit finished = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [31:0] mem [256];
   logic [31:0] e_addr [8];
   logic [31:0] e_len  [8];
   bit          e_dir  [8];
   logic [3:0]  e_mode [8];
   int  exp_n = 0, burst_idx = 0, err_at = -1, last_idx = 0;
   bit  both = 0, spur = 0;
   int  rd_cnt = 0, done_cnt = 0, drv_cyc = -10;
   bit  done_expected_now = 0;

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // memory responder, latency 1..3
   initial forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (mem_rd_req) begin
         logic [31:0] a;
         a = mem_rd_addr;
         // R3: word order within a descriptor
         check(a[3:0] == 4'((rd_cnt % 4) * 4), "R3 read offset",
               64'(a[3:0]), 64'((rd_cnt % 4) * 4));
         rd_cnt++;
         repeat ($urandom_range(1, 3)) @(negedge clk);
         mem_rd_valid = 1'b1;
         mem_rd_data  = mem[a[9:2]];
      end
   end

   // data mover model
   initial forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      xfer_err  = 1'b0;
      if (xfer_req) begin
         if (burst_idx >= exp_n) begin
            check(0, "R4 unexpected burst", 64'(burst_idx), 64'(exp_n));
         end else begin
            check(xfer_addr == e_addr[burst_idx], "R2 address",
                  64'(xfer_addr), 64'(e_addr[burst_idx]));
            check(xfer_bytes == {e_len[burst_idx], 3'b000}, "R2 byte count",
                  64'(xfer_bytes), 64'({e_len[burst_idx], 3'b000}));
            check(xfer_dir == e_dir[burst_idx], "R2 direction",
                  64'(xfer_dir), 64'(e_dir[burst_idx]));
            check(xfer_mode == e_mode[burst_idx], "R2 mode",
                  64'(xfer_mode), 64'(e_mode[burst_idx]));
         end
         if (spur && burst_idx == 0) begin
            start_i     = 1'b1;
            start_ptr_i = 32'h0000_0280;
            @(negedge clk);
            start_i = 1'b0;
         end
         repeat ($urandom_range(0, 3)) @(negedge clk);
         check(xfer_req == 1'b1, "R2 request held", 64'(xfer_req), 64'd1);
         if (burst_idx == err_at) begin
            xfer_err  = 1'b1;
            xfer_done = both;
         end else begin
            xfer_done = 1'b1;
            if (burst_idx == last_idx) drv_cyc = cyc;
         end
         burst_idx++;
      end
   end

   // done monitor
   initial forever begin
      @(negedge clk);
      if (done) begin
         done_cnt++;
         // R5: done one cycle after completion of the final entry
         check(cyc == drv_cyc + 1, "R5 done timing", 64'(cyc), 64'(drv_cyc + 1));
         check(busy == 1'b0, "R5 idle with done", 64'(busy), 64'd0);
      end
   end

   function automatic logic [31:0] slot_base(int s0, int i);
      return 32'(((s0 + i * 7) % 64) * 16);
   endfunction

   // kind: 0 normal, 1 zero length at k, 2 unaligned next at k,
   //       3 unaligned next on final, 4 bus error at k, 5 error+done on final
   task automatic run_chain(int n, int kind, int k, bit spur_en, string tag);
      int s0, nb, nr, t;
      bit dn, sq, bs;
      s0 = $urandom_range(0, 63);
      for (int i = 0; i < n; i++) begin
         logic [31:0] b, nx;
         logic [7:0]  fl, mb;
         bit lst;
         b   = slot_base(s0, i);
         lst = (i == n - 1);
         e_addr[i] = $urandom;
         e_len[i]  = (kind == 1 && i == k) ? 32'd0 : 32'($urandom_range(1, 8191));
         e_dir[i]  = 1'($urandom);
         e_mode[i] = 4'($urandom);
         mb = {4'($urandom), e_mode[i]};
         fl = 8'h10 | (e_dir[i] ? 8'h20 : 8'h00) | (lst ? 8'h80 : 8'h00);
         if (lst) nx = (kind == 3) ? (($urandom & 32'h3F8) | 32'd5) : 32'd0;
         else     nx = slot_base(s0, i + 1) | ((kind == 2 && i == k) ? 32'd4 : 32'd0);
         mem[b[9:2]]     = e_addr[i];
         mem[b[9:2] + 1] = e_len[i];
         mem[b[9:2] + 2] = {16'($urandom), mb, fl};
         mem[b[9:2] + 3] = nx;
      end
      dn = 0; sq = 0; bs = 0; both = 0; err_at = -1;
      case (kind)
         1, 2: begin nb = k; nr = 4 * (k + 1); sq = 1; end
         4:    begin nb = k + 1; nr = 4 * (k + 1); bs = 1; err_at = k; end
         5:    begin nb = n; nr = 4 * n; bs = 1; err_at = n - 1; both = 1; end
         default: begin nb = n; nr = 4 * n; dn = 1; end
      endcase
      exp_n = nb; burst_idx = 0; last_idx = n - 1; spur = spur_en;
      rd_cnt = 0; done_cnt = 0; drv_cyc = -10;
      @(negedge clk);
      start_i = 1'b1; start_ptr_i = slot_base(s0, 0);
      @(negedge clk);
      start_i = 1'b0;
      t = 0;
      while (busy && t < 4000) begin @(negedge clk); t++; end
      check(t < 4000, {tag, " walk ends"}, 64'(t), 64'd4000);
      @(negedge clk);
      check(burst_idx == nb, {tag, " burst count"}, 64'(burst_idx), 64'(nb));
      check(rd_cnt == nr, {tag, " R3 read count"}, 64'(rd_cnt), 64'(nr));
      check(done_cnt == int'(dn), {tag, " done count"}, 64'(done_cnt), 64'(dn));
      check(err_seq == sq, {tag, " seq flag"}, 64'(err_seq), 64'(sq));
      check(err_bus == bs, {tag, " bus flag"}, 64'(err_bus), 64'(bs));
      check(busy == 1'b0, {tag, " idle"}, 64'(busy), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog", 64'(cyc), 64'd0);
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 256; i++) mem[i] = $urandom;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({busy, xfer_req, mem_rd_req, done, err_seq, err_bus} == 6'b0,
            "R1 reset state", 64'({busy, xfer_req, mem_rd_req, done, err_seq, err_bus}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_chain(1, 0, 0, 0, "R2 single entry");
      run_chain(4, 0, 0, 0, "R4 four entries");
      run_chain(3, 1, 0, 0, "R6 zero length first");
      run_chain(5, 1, 3, 0, "R6 zero length mid");
      run_chain(4, 0, 0, 0, "R9 flags clear after fault");
      run_chain(4, 2, 1, 0, "R7 unaligned next");
      run_chain(3, 3, 0, 0, "R7 final next ignored");
      run_chain(4, 4, 2, 0, "R8 bus error mid");
      run_chain(3, 5, 2, 0, "R8 error with done");
      run_chain(1, 5, 0, 0, "R8 error with done single");
      run_chain(3, 0, 0, 1, "R9 start while busy");
      for (int r = 0; r < 60; r++) begin
         int n, kind, k;
         n    = $urandom_range(1, 6);
         kind = $urandom_range(0, 5);
         k    = $urandom_range(0, n - 1);
         if (kind == 2 && n == 1) kind = 0;
         if (kind == 2 && k == n - 1) k = n - 2;
         run_chain(n, kind, k, 1'($urandom_range(0, 1)), "R4 random chain");
      end
      finish_run();
   end
endmodule